// File: doc/BRIEF.md
# Byte/Word Move Unit with Character Display Snoop

This block carries out the move instructions of a 16-bit machine in both byte and word sizes. It accepts the upper ten bits of an instruction word together with a size flag. It pulls any extension words it needs from a separate word stream. It reads and writes a 16-entry register file and drives a byte-addressed data memory. A register move copies either a register or an immediate into a register. A memory move reads or writes the memory at an address that is either an absolute extension word or a base register plus a 16-bit offset word. Words in memory are little-endian.

Word accesses must be even. An odd word address raises a sticky error and halt output, and the access is never issued. When the display-enable input is high at the time of a store, every stored byte whose address falls inside a parameterised character window is sent out on a display stream as (window offset, character). The lower address goes first. Instruction fetch and arithmetic belong to other blocks.

The instruction, extension and display interfaces are valid/ready streams. A transfer happens on a rising edge where both valid and ready are high. The block raises `ins_ready` only when idle. It raises `ext_ready` only in a state that consumes an extension word. While `dsp_ready` is low it holds the display beat unchanged and takes no new instruction. The memory answers a read one cycle after `mem_req`.

Top module: `lsu_move_unit`

## Requirements
- R1: After reset `ins_ready` is 1 and `ext_ready`, `mem_req`, `rf_we`, `dsp_valid` and `halt_err` are 0.
- R2: With `ins_field[10]`=0 and `ins_field[6]`=0, the register named by bits 10:7 is copied to the register named by bits 15:12.
- R3: With `ins_field[10]`=0 and `ins_field[6]`=1, the next extension word is written to the register named by bits 15:12.
- R4: With bit 10=1 and bit 11=0, the next extension word is the byte address. A word read returns {mem[a+1], mem[a]}, and a word write stores the low byte at a and the high byte at a+1.
- R5: With bits 10 and 11 both 1, the address is base + offset modulo 2^16, where the offset is the next extension word. A load (bit 12=0) takes its base from bits 9:7 and writes bits 15:13. A store (bit 12=1) takes its base from bits 15:13.
- R6: Store data is the register named by bits 9:7 when bit 6 is 0. When bit 6 is 1 it is the extension word that follows the address word.
- R7: With `ins_word_op`=0, register moves and stores keep only the low 8 bits and loads zero-extend the byte at the address. No register is written with a nonzero upper byte.
- R8: A word access at an odd address writes no memory and no register. It sets `halt_err`, which stays high until reset, and `ins_ready` and `ext_ready` stay low from then on.
- R9: A store while `disp_enable` is 1 emits one display beat for each stored byte whose address a satisfies DISP_BASE <= a < DISP_BASE+DISP_SIZE. The beat carries offset a-DISP_BASE and the byte, lower address first. No beat is emitted when `disp_enable` is 0 or the byte is outside the window.
- R10: While `dsp_valid` is 1 and `dsp_ready` is 0, the offset and character hold, and no instruction is accepted until every beat of the store has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction stream valid |
| ins_ready | output | 1 | Instruction stream ready (idle) |
| ins_word_op | input | 1 | 1 = word move, 0 = byte move |
| ins_field | input | 10 | Instruction bits 15:6 |
| ext_valid | input | 1 | Extension word valid |
| ext_ready | output | 1 | Extension word ready |
| ext_data | input | 16 | Extension word (immediate, address or offset) |
| disp_enable | input | 1 | Display forwarding enable |
| rf_ra_addr | output | 4 | Register read port A index (source or base) |
| rf_ra_data | input | 16 | Register read port A data |
| rf_rb_addr | output | 4 | Register read port B index (store data) |
| rf_rb_data | input | 16 | Register read port B data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Access size: 1 = two bytes, 0 = one byte |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data, byte at address in bits 7:0 |
| mem_rdata | input | 16 | Read data one cycle after request, byte at address in bits 7:0 |
| dsp_valid | output | 1 | Display beat valid |
| dsp_ready | input | 1 | Display beat ready |
| dsp_offset | output | $clog2(DISP_SIZE) | Character offset inside the window |
| dsp_char | output | 8 | Character byte |
| halt_err | output | 1 | Sticky alignment error / halt request |

## Verification
The main function is tried with random register moves, immediate moves, loads and stores of both sizes. Absolute and register-plus-offset addresses are aimed either around the display window or anywhere in memory. Comparing whole register and memory images after each instruction tells apart the two base-register fields, the two store-data sources, and truncation against zero-extension. Random gaps on the extension stream and random display back-pressure separate correct handshaking from beats that are dropped or duplicated. Directed cases cover an address that wraps past 0xFFFF, stores on the window's first and last bytes and just outside it, stores with forwarding off, and odd word loads and stores, which must leave all state untouched and latch the halt.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MOVE,
    ST_ADDR,
    ST_SDATA,
    ST_STORE,
    ST_LOAD,
    ST_LWB,
    ST_DISP,
    ST_HALT
  } lsu_state_e;

  // decoded view of instruction bits 15:6
  typedef struct packed {
    logic       is_mem;    // memory access instead of register move
    logic       use_base;  // base register plus offset word
    logic       is_store;  // store instead of load
    logic       use_imm;   // immediate source
    logic [3:0] mv_src;
    logic [3:0] mv_dst;
    logic [3:0] base_reg;
    logic [3:0] ld_dst;
    logic [3:0] st_src;
  } lsu_dec_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [15:6] ins,
  output lsu_dec_t    dec
);

  always_comb begin
    dec.is_mem   = ins[10];
    dec.use_base = ins[11];
    dec.is_store = ins[12];
    dec.use_imm  = ins[6];
    dec.mv_src   = ins[10:7];
    dec.mv_dst   = ins[15:12];
    dec.ld_dst   = {1'b0, ins[15:13]};
    dec.st_src   = {1'b0, ins[9:7]};
    // stores index their base through the destination field, loads through operand 2
    dec.base_reg = ins[12] ? {1'b0, ins[15:13]} : {1'b0, ins[9:7]};
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW = 16
) (
  input  logic          use_base,
  input  logic          word,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] addr,
  output logic          misaligned
);

  assign addr       = use_base ? base + ext : ext;
  assign misaligned = word & addr[0];

endmodule

// File: rtl/lsu_snoop.sv
module lsu_snoop #(
  parameter int AW        = 16,
  parameter int NB        = 2,
  parameter int WIN_BASE  = 16'h0400,
  parameter int WIN_SIZE  = 128,
  localparam int OW       = $clog2(WIN_SIZE)
) (
  input  logic           en,
  input  logic           word,
  input  logic [AW-1:0]  addr,
  output logic [NB-1:0]  hit,
  output logic [NB*OW-1:0] off
);

  localparam logic [AW:0] LO = (AW+1)'(WIN_BASE);
  localparam logic [AW:0] HI = (AW+1)'(WIN_BASE + WIN_SIZE);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [AW-1:0] lane_addr;
    logic          in_win;
    logic          lane_used;
    assign lane_addr = addr + AW'(i);
    assign in_win    = ({1'b0, lane_addr} >= LO) && ({1'b0, lane_addr} < HI);
    assign lane_used = (i == 0) || word;
    assign hit[i]    = en && lane_used && in_win;
    assign off[i*OW +: OW] = OW'(lane_addr - AW'(WIN_BASE));
  end

endmodule

// File: rtl/lsu_move_unit.sv
module lsu_move_unit
  import lsu_pkg::*;
#(
  parameter int DISP_BASE = 16'h0400,
  parameter int DISP_SIZE = 128,
  localparam int AW = 16,
  localparam int NB = AW / 8,
  localparam int RI = 4,
  localparam int OW = $clog2(DISP_SIZE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic          ins_word_op,
  input  logic [15:6]   ins_field,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic [AW-1:0] ext_data,
  input  logic          disp_enable,
  output logic [RI-1:0] rf_ra_addr,
  input  logic [AW-1:0] rf_ra_data,
  output logic [RI-1:0] rf_rb_addr,
  input  logic [AW-1:0] rf_rb_data,
  output logic          rf_we,
  output logic [RI-1:0] rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          dsp_valid,
  input  logic          dsp_ready,
  output logic [OW-1:0] dsp_offset,
  output logic [7:0]    dsp_char,
  output logic          halt_err
);

  lsu_state_e       state_q;
  logic [15:6]      ins_q;
  logic             word_q;
  logic [AW-1:0]    addr_q;
  logic [AW-1:0]    data_q;
  logic [NB-1:0]    pend_q;
  logic [NB*OW-1:0] offs_q;
  logic             halt_q;

  lsu_dec_t         dec;
  logic [AW-1:0]    ag_addr;
  logic             ag_misal;
  logic [NB-1:0]    sn_hit;
  logic [NB*OW-1:0] sn_off;
  logic [AW-1:0]    mv_val;
  logic             lane;
  logic [NB-1:0]    pend_nx;

  lsu_decode u_dec (
    .ins (ins_q),
    .dec (dec)
  );

  lsu_agen #(.AW(AW)) u_agen (
    .use_base   (dec.use_base),
    .word       (word_q),
    .base       (rf_ra_data),
    .ext        (ext_data),
    .addr       (ag_addr),
    .misaligned (ag_misal)
  );

  lsu_snoop #(
    .AW       (AW),
    .NB       (NB),
    .WIN_BASE (DISP_BASE),
    .WIN_SIZE (DISP_SIZE)
  ) u_snoop (
    .en   (disp_enable),
    .word (word_q),
    .addr (addr_q),
    .hit  (sn_hit),
    .off  (sn_off)
  );

  function automatic logic [AW-1:0] size_fit(input logic w, input logic [AW-1:0] v);
    return w ? v : {{(AW-8){1'b0}}, v[7:0]};
  endfunction

  // register ports
  assign rf_ra_addr = (state_q == ST_MOVE) ? dec.mv_src : dec.base_reg;
  assign rf_rb_addr = dec.st_src;
  assign mv_val     = dec.use_imm ? ext_data : rf_ra_data;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dec.mv_dst;
    rf_wdata = size_fit(word_q, mv_val);
    if (state_q == ST_MOVE) begin
      rf_we = !dec.use_imm || ext_valid;
    end else if (state_q == ST_LWB) begin
      rf_we    = 1'b1;
      rf_waddr = dec.ld_dst;
      rf_wdata = size_fit(word_q, mem_rdata);
    end
  end

  // stream handshakes
  assign ins_ready = (state_q == ST_IDLE);
  assign ext_ready = (state_q == ST_ADDR) || (state_q == ST_SDATA) ||
                     ((state_q == ST_MOVE) && dec.use_imm);

  // memory port
  assign mem_req   = (state_q == ST_STORE) || (state_q == ST_LOAD);
  assign mem_we    = (state_q == ST_STORE);
  assign mem_word  = word_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = size_fit(word_q, data_q);

  // display port: lowest pending lane first
  assign lane       = !pend_q[0];
  assign dsp_valid  = (state_q == ST_DISP);
  assign dsp_offset = lane ? offs_q[OW +: OW] : offs_q[0 +: OW];
  assign dsp_char   = lane ? data_q[15:8] : data_q[7:0];
  assign pend_nx    = pend_q & ~(NB'(1) << lane);

  assign halt_err = halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ins_q   <= '0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      pend_q  <= '0;
      offs_q  <= '0;
      halt_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ins_valid) begin
            ins_q   <= ins_field;
            word_q  <= ins_word_op;
            // bit 10 of the incoming word picks the memory path
            state_q <= ins_field[10] ? ST_ADDR : ST_MOVE;
          end
        end
        ST_MOVE: begin
          if (!dec.use_imm || ext_valid) state_q <= ST_IDLE;
        end
        ST_ADDR: begin
          if (ext_valid) begin
            addr_q <= ag_addr;
            if (ag_misal) begin
              halt_q  <= 1'b1;
              state_q <= ST_HALT;
            end else if (dec.is_store) begin
              data_q  <= rf_rb_data;
              state_q <= dec.use_imm ? ST_SDATA : ST_STORE;
            end else begin
              state_q <= ST_LOAD;
            end
          end
        end
        ST_SDATA: begin
          if (ext_valid) begin
            data_q  <= ext_data;
            state_q <= ST_STORE;
          end
        end
        ST_STORE: begin
          pend_q  <= sn_hit;
          offs_q  <= sn_off;
          state_q <= (|sn_hit) ? ST_DISP : ST_IDLE;
        end
        ST_LOAD: state_q <= ST_LWB;
        ST_LWB:  state_q <= ST_IDLE;
        ST_DISP: begin
          if (dsp_ready) begin
            pend_q <= pend_nx;
            if (pend_nx == '0) state_q <= ST_IDLE;
          end
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsu_move_unit_chk.sv
module lsu_move_unit_chk #(
  parameter int OW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_ready,
  input logic          ext_ready,
  input logic          mem_req,
  input logic          mem_word,
  input logic [15:0]   mem_addr,
  input logic          rf_we,
  input logic [15:0]   rf_wdata,
  input logic          word_op,
  input logic          dsp_valid,
  input logic          dsp_ready,
  input logic [OW-1:0] dsp_offset,
  input logic [7:0]    dsp_char,
  input logic          halt_err
);

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_err |=> halt_err);

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_err |-> (!mem_req && !rf_we && !ins_ready && !ext_ready));

  p_word_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_word) |-> !mem_addr[0]);

  p_byte_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !word_op) |-> (rf_wdata[15:8] == 8'h00));

  p_dsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_offset) && $stable(dsp_char)));

  p_dsp_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> !ins_ready);

endmodule

bind lsu_move_unit lsu_move_unit_chk #(.OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_ready  (ins_ready),
  .ext_ready  (ext_ready),
  .mem_req    (mem_req),
  .mem_word   (mem_word),
  .mem_addr   (mem_addr),
  .rf_we      (rf_we),
  .rf_wdata   (rf_wdata),
  .word_op    (word_q),
  .dsp_valid  (dsp_valid),
  .dsp_ready  (dsp_ready),
  .dsp_offset (dsp_offset),
  .dsp_char   (dsp_char),
  .halt_err   (halt_err)
);

// File: tb/test_lsu_move_unit.sv
`timescale 1ns/1ps
module test_lsu_move_unit;
  localparam int DB = 16'h0400;
  localparam int DS = 128;
  localparam int OW = 7;
  localparam int MB = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ins_valid = 0, ins_ready, ins_word_op = 0;
  logic [15:6] ins_field = '0;
  logic ext_valid = 0, ext_ready;
  logic [15:0] ext_data = '0;
  logic disp_enable = 0;
  logic [3:0] rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [15:0] rf_ra_data, rf_rb_data, rf_wdata;
  logic rf_we, mem_req, mem_we, mem_word;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic dsp_valid, dsp_ready = 1;
  logic [OW-1:0] dsp_offset;
  logic [7:0] dsp_char;
  logic halt_err;

  lsu_move_unit i_lsu_move_unit (.*);

  logic [15:0] regs [16];
  logic [7:0]  mem  [MB];
  logic [15:0] rregs[16];
  logic [7:0]  rmem [MB];
  logic [OW+7:0] exp_q[$];
  int n_chk = 0, n_fail = 0;

  function automatic int ma(input logic [15:0] a);
    return int'(a[10:0]);
  endfunction

  assign rf_ra_data = regs[rf_ra_addr];
  assign rf_rb_data = regs[rf_rb_addr];

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && mem_we) begin
      mem[ma(mem_addr)] <= mem_wdata[7:0];
      if (mem_word) mem[ma(mem_addr + 16'd1)] <= mem_wdata[15:8];
    end
    mem_rdata <= {mem[ma(mem_addr + 16'd1)], mem[ma(mem_addr)]};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // display monitor (R9, R10)
  always @(posedge clk) begin
    if (rst_n && dsp_valid && dsp_ready) begin
      if (exp_q.size() == 0) chk(0, "R9", "unexpected display beat", {dsp_offset, dsp_char}, 0);
      else begin
        logic [OW+7:0] e;
        e = exp_q.pop_front();
        chk({dsp_offset, dsp_char} == e, "R9", "display beat", {dsp_offset, dsp_char}, e);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      dsp_ready = ($urandom % 4) != 0;
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    report();
  end

  task automatic push_ins(input logic [15:6] b, input bit w);
    ins_valid = 1; ins_field = b; ins_word_op = w;
    #1;
    while (!ins_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic push_ext(input logic [15:0] v);
    repeat ($urandom % 3) @(negedge clk);
    ext_valid = 1; ext_data = v;
    #1;
    while (!ext_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    ext_valid = 0;
  endtask

  task automatic compare_state(input string req);
    bit ok = 1;
    for (int i = 0; i < 16; i++) if (regs[i] !== rregs[i]) ok = 0;
    chk(ok, req, "register file image", 0, 0);
    ok = 1;
    for (int i = 0; i < MB; i++) if (mem[i] !== rmem[i]) ok = 0;
    chk(ok, req, "memory image", 0, 0);
    chk(exp_q.size() == 0, "R10", "display beats drained", exp_q.size(), 0);
  endtask

  // executes one move in the reference model and drives it into the DUT
  task automatic run_ins(input logic [15:6] b, input bit w, input bit den,
                         input logic [15:0] e0, input logic [15:0] e1, input string req);
    logic [15:0] v, a, d;
    logic [3:0] base;
    disp_enable = den;
    push_ins(b, w);
    if (!b[10]) begin
      if (b[6]) push_ext(e0);
      v = b[6] ? e0 : rregs[b[10:7]];
      rregs[b[15:12]] = w ? v : {8'h00, v[7:0]};
    end else begin
      push_ext(e0);
      base = b[12] ? {1'b0, b[15:13]} : {1'b0, b[9:7]};
      a = b[11] ? rregs[base] + e0 : e0;
      if (w && a[0]) begin
        repeat (3) @(negedge clk);
        chk(halt_err == 1'b1, "R8", "halt on odd word address", halt_err, 1);
        chk(ins_ready == 1'b0 && ext_ready == 1'b0, "R8", "streams closed after halt",
            {ins_ready, ext_ready}, 0);
        compare_state("R8");
        return;
      end
      if (b[12]) begin
        d = b[6] ? e1 : rregs[b[9:7]];
        if (b[6]) push_ext(e1);
        rmem[ma(a)] = d[7:0];
        if (w) rmem[ma(a + 16'd1)] = d[15:8];
        for (int i = 0; i < (w ? 2 : 1); i++) begin
          logic [15:0] la;
          la = a + 16'(i);
          if (den && la >= 16'(DB) && la < 16'(DB + DS))
            exp_q.push_back({OW'(la - 16'(DB)), (i == 0) ? d[7:0] : d[15:8]});
        end
      end else begin
        rregs[b[15:13]] = w ? {rmem[ma(a + 16'd1)], rmem[ma(a)]} : {8'h00, rmem[ma(a)]};
      end
    end
    while (!ins_ready && !halt_err) @(negedge clk);
    compare_state(req);
  endtask

  task automatic rand_ins();
    logic [15:6] b;
    bit w;
    int kind;
    logic [15:0] tgt, e0;
    logic [3:0] base;
    kind = $urandom % 4;
    w = $urandom % 2;
    b = 10'($urandom);
    if (kind < 2) begin
      b[10] = 0; b[6] = (kind == 1);
      run_ins(b, w, 0, 16'($urandom), 0, kind == 1 ? "R3" : "R2");
    end else begin
      b[10] = 1; b[12] = (kind == 3);
      tgt = ($urandom % 2) ? 16'(DB - 8 + ($urandom % (DS + 16))) : 16'($urandom % MB);
      if (w) tgt[0] = 0;
      base = b[12] ? {1'b0, b[15:13]} : {1'b0, b[9:7]};
      e0 = b[11] ? tgt - rregs[base] : tgt;
      run_ins(b, w, $urandom % 2, e0, 16'($urandom), b[11] ? "R5" : "R4");
    end
  endtask

  // field builders
  function automatic logic [15:6] mem_op(input bit st, input bit rb, input bit imm,
                                         input logic [2:0] dst, input logic [2:0] op2);
    logic [15:6] b;
    b = '0; b[15:13] = dst; b[12] = st; b[11] = rb; b[10] = 1; b[9:7] = op2; b[6] = imm;
    return b;
  endfunction

  initial begin
    void'($urandom(32'd20250330));
    for (int i = 0; i < 16; i++) begin regs[i] = 16'($urandom); rregs[i] = regs[i]; end
    for (int i = 0; i < MB; i++) begin mem[i] = 8'($urandom); rmem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ins_ready == 1 && ext_ready == 0 && mem_req == 0 && rf_we == 0 &&
        dsp_valid == 0 && halt_err == 0, "R1", "reset outputs",
        {ins_ready, ext_ready, mem_req, rf_we, dsp_valid, halt_err}, 6'b100000);
    rst_n = 1;
    @(negedge clk);

    // R2 register copy, word and byte (R7)
    rregs[3] = 16'hBEEF; regs[3] = 16'hBEEF;
    run_ins({4'd9, 4'd3, 1'b0, 1'b0} << 0, 1, 0, 0, 0, "R2");
    run_ins({4'd10, 4'd3, 1'b0, 1'b0}, 0, 0, 0, 0, "R7");
    // R3 immediate, byte truncation
    run_ins({4'd12, 4'd0, 1'b0, 1'b1}, 0, 0, 16'hA5C3, 0, "R7");
    run_ins({4'd13, 4'd0, 1'b0, 1'b1}, 1, 0, 16'h1234, 0, "R3");
    // R4 absolute word store then byte and word load
    rregs[2] = 16'hC0DE; regs[2] = 16'hC0DE;
    run_ins(mem_op(1, 0, 0, 3'd0, 3'd2), 1, 0, 16'h0100, 0, "R4");
    run_ins(mem_op(0, 0, 0, 3'd5, 3'd0), 0, 0, 16'h0101, 0, "R4");
    run_ins(mem_op(0, 0, 0, 3'd6, 3'd0), 1, 0, 16'h0100, 0, "R4");
    // R5 base + offset wrapping past 0xFFFF, store base from dst field
    rregs[1] = 16'hFFF0; regs[1] = 16'hFFF0;
    run_ins(mem_op(1, 1, 1, 3'd1, 3'd4), 1, 1, 16'h0410, 16'h6162, "R5");
    run_ins(mem_op(0, 1, 0, 3'd7, 3'd1), 1, 0, 16'h0410, 0, "R5");
    // R9 window edges, disabled forwarding
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 0, 1, 16'(DB + DS - 1), 16'h0041, "R9");
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 0, 1, 16'(DB + DS), 16'h0042, "R9");
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 1, 1, 16'(DB - 2), 16'h4443, "R9");
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 1, 1, 16'(DB + DS - 2), 16'h4645, "R9");
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 1, 0, 16'(DB + 4), 16'h4847, "R9");
    // R6 register data source, R10 under random back-pressure
    run_ins(mem_op(1, 0, 0, 3'd0, 3'd6), 1, 1, 16'(DB + 10), 0, "R6");

    for (int n = 0; n < 400; n++) rand_ins();

    // R8 odd word store, then check nothing moved and state is frozen
    run_ins(mem_op(1, 0, 1, 3'd0, 3'd0), 1, 1, 16'(DB + 3), 16'hFFFF, "R8");
    repeat (5) @(negedge clk);
    chk(halt_err == 1, "R8", "halt still held", halt_err, 1);
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk(halt_err == 0 && ins_ready == 1, "R1", "reset clears halt", {halt_err, ins_ready}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    rregs[4] = 16'h0201; regs[4] = 16'h0201;
    run_ins(mem_op(0, 1, 0, 3'd2, 3'd4), 1, 0, 16'h0000, 0, "R8");
    report();
  end

endmodule